// File: doc/BRIEF.md
# Truncating Single-Precision Multiplier

This block multiplies two binary floating-point operands that use the standard 32-bit layout: one sign bit, an 8-bit exponent with a bias of 127, and a 23-bit fraction. It returns the product in the same three fields. The block is purely combinational. It is meant to sit inside a fixed-function transcendental datapath whose operands are always normal numbers or exact zeros. Because of that, it has no handling for subnormals, infinities or NaNs, and it raises no exception flags.

A zero operand is recognised from its exponent field alone. When that field is zero, the result is a positive zero. Otherwise both fractions regain their hidden leading one and are multiplied to a double-width product. A single test of the product's top bit picks the normalisation. The result fraction is then cut from the product with no rounding. The result exponent is the sum of the input exponents, re-biased, and it wraps silently if it leaves the 8-bit range.

Top module: `fpm_mul_trunc`

## Requirements
- R1: When either operand's exponent field is 0, the result is sign 0, exponent 0 and fraction 0, whatever the signs and fractions are.
- R2: For nonzero operands, the result sign is the XOR of the two operand signs.
- R3: The significand product is the exact 48-bit product of the two 24-bit significands, each formed as {1, fraction}. The multiplier variant chosen by parameter does not change it.
- R4: The leading one of the significand product sits at bit 47 or bit 46.
- R5: When product bit 47 is 1, the result exponent is ea+eb-126 and the result fraction is product bits 46 down to 24.
- R6: When product bit 47 is 0, the result exponent is ea+eb-127 and the result fraction is product bits 45 down to 23.
- R7: Discarded product bits never round the fraction up. For example, 0x3FFFFFFF times itself gives 0x407FFFFE.
- R8: The result exponent wraps modulo 256 without any flag. Two operands with exponent 254 give exponent 125, and two with exponent 1 give exponent 131.
- R9: An operand with exponent 0 and a nonzero fraction is still treated as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | 8 | Biased exponent of operand A |
| a_frac | input | 23 | Fraction of operand A, hidden one omitted |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | 8 | Biased exponent of operand B |
| b_frac | input | 23 | Fraction of operand B, hidden one omitted |
| p_sign | output | 1 | Sign of the product |
| p_exp | output | 8 | Biased exponent of the product, wrapping |
| p_frac | output | 23 | Truncated fraction of the product |

## Verification
The bench uses the default field widths and sets the significand multiplier to the explicit shift-and-add array rather than the native operator. In that configuration the internal cross-check between the two product forms runs on every operand pair. Under those widths, directed vectors reach both normalisation branches, the all-ones truncation case, exponent wrap at both ends, and zero operands that carry nonzero fractions. Random operands with exponents limited to 64..190 compare the result against an exact-product model.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
   localparam int unsigned FPM_EXP_W  = 8;
   localparam int unsigned FPM_FRAC_W = 23;

   typedef enum logic {
      MULT_NATIVE   = 1'b0,
      MULT_SHIFTADD = 1'b1
   } fpm_mult_style_e;

   function automatic int unsigned fpm_bias(input int unsigned exp_w);
      return (1 << (exp_w - 1)) - 1;
   endfunction
endpackage

// File: rtl/fpm_sig_mult.sv
module fpm_sig_mult
   import fpm_pkg::*;
#(
   parameter int unsigned     SIG_W = 24,
   parameter fpm_mult_style_e STYLE = MULT_NATIVE,
   localparam int unsigned    PROD_W = 2 * SIG_W
) (
   input  logic [SIG_W-1:0]  sig_a,
   input  logic [SIG_W-1:0]  sig_b,
   output logic [PROD_W-1:0] prod
);
   if (SIG_W < 2) begin : g_bad_width
      $error("fpm_sig_mult: SIG_W must be at least 2");
   end

   if (STYLE == MULT_SHIFTADD) begin : g_shiftadd
      logic [PROD_W-1:0] acc;
      always_comb begin
         acc = '0;
         for (int i = 0; i < SIG_W; i++) begin
            if (sig_a[i]) acc = acc + ({{SIG_W{1'b0}}, sig_b} << i);
         end
      end
      assign prod = acc;

      always_comb begin
         // R3: explicit array must agree with the native product
         assert_array_matches_R3: assert (acc ==
            ({{SIG_W{1'b0}}, sig_a} * {{SIG_W{1'b0}}, sig_b}))
            else $error("R3: shift-add product mismatch");
      end
   end else begin : g_native
      assign prod = {{SIG_W{1'b0}}, sig_a} * {{SIG_W{1'b0}}, sig_b};
   end
endmodule

// File: rtl/fpm_norm_trunc.sv
module fpm_norm_trunc #(
   parameter int unsigned  FRAC_W = 23,
   localparam int unsigned SIG_W  = FRAC_W + 1,
   localparam int unsigned PROD_W = 2 * SIG_W
) (
   input  logic [PROD_W-1:0] prod,
   output logic              top_set,
   output logic [FRAC_W-1:0] frac
);
   assign top_set = prod[PROD_W-1];
   assign frac    = top_set ? prod[PROD_W-2 -: FRAC_W]
                            : prod[PROD_W-3 -: FRAC_W];

   always_comb begin
      // R4: product of two hidden-one significands lands in [2^46, 2^48)
      assert_leading_one_R4: assert (prod[PROD_W-1] | prod[PROD_W-2])
         else $error("R4: leading one below bit 46");
   end
endmodule

// File: rtl/fpm_exp_adjust.sv
module fpm_exp_adjust #(
   parameter int unsigned  EXP_W = 8,
   localparam int unsigned SUM_W = EXP_W + 2,
   localparam int unsigned BIAS  = (1 << (EXP_W - 1)) - 1
) (
   input  logic [EXP_W-1:0] exp_a,
   input  logic [EXP_W-1:0] exp_b,
   input  logic             top_set,
   output logic [EXP_W-1:0] exp_out
);
   localparam logic [SUM_W-1:0] BIAS_EXT = SUM_W'(BIAS);

   logic [SUM_W-1:0] sum;
   always_comb begin
      sum = {2'b00, exp_a} + {2'b00, exp_b}
          + {{(SUM_W-1){1'b0}}, top_set} - BIAS_EXT;
   end
   assign exp_out = sum[EXP_W-1:0];
endmodule

// File: rtl/fpm_mul_trunc.sv
module fpm_mul_trunc
   import fpm_pkg::*;
#(
   parameter int unsigned     EXP_W  = FPM_EXP_W,
   parameter int unsigned     FRAC_W = FPM_FRAC_W,
   parameter fpm_mult_style_e STYLE  = MULT_NATIVE,
   localparam int unsigned    SIG_W  = FRAC_W + 1,
   localparam int unsigned    PROD_W = 2 * SIG_W
) (
   input  logic              a_sign,
   input  logic [EXP_W-1:0]  a_exp,
   input  logic [FRAC_W-1:0] a_frac,
   input  logic              b_sign,
   input  logic [EXP_W-1:0]  b_exp,
   input  logic [FRAC_W-1:0] b_frac,
   output logic              p_sign,
   output logic [EXP_W-1:0]  p_exp,
   output logic [FRAC_W-1:0] p_frac
);
   if (EXP_W < 2 || FRAC_W < 1) begin : g_bad_fields
      $error("fpm_mul_trunc: EXP_W >= 2 and FRAC_W >= 1 required");
   end

   logic              any_zero;
   logic [PROD_W-1:0] prod;
   logic              top_set;
   logic [FRAC_W-1:0] n_frac;
   logic [EXP_W-1:0]  n_exp;

   assign any_zero = (a_exp == '0) || (b_exp == '0);

   fpm_sig_mult #(.SIG_W(SIG_W), .STYLE(STYLE)) u_mult (
      .sig_a (({1'b1, a_frac})),
      .sig_b (({1'b1, b_frac})),
      .prod  (prod)
   );

   fpm_norm_trunc #(.FRAC_W(FRAC_W)) u_norm (
      .prod    (prod),
      .top_set (top_set),
      .frac    (n_frac)
   );

   fpm_exp_adjust #(.EXP_W(EXP_W)) u_exp (
      .exp_a   (a_exp),
      .exp_b   (b_exp),
      .top_set (top_set),
      .exp_out (n_exp)
   );

   always_comb begin
      if (any_zero) begin
         p_sign = 1'b0;
         p_exp  = '0;
         p_frac = '0;
      end else begin
         p_sign = a_sign ^ b_sign;
         p_exp  = n_exp;
         p_frac = n_frac;
      end
   end

   always_comb begin
      // R1: zero exponent on either side yields positive zero
      if (a_exp == '0 || b_exp == '0) begin
         assert_zero_force_R1: assert (!p_sign && p_exp == '0 && p_frac == '0)
            else $error("R1: zero operand gave nonzero result");
      end
      // R2: nonzero sign follows the operand signs
      if (a_exp != '0 && b_exp != '0) begin
         assert_sign_xor_R2: assert (p_sign == (a_sign ^ b_sign))
            else $error("R2: sign mismatch");
      end
   end
endmodule

// File: tb/fpm_mul_trunc_tb_top.sv
module fpm_mul_trunc_tb_top;
   import fpm_pkg::*;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        a_sign, b_sign, p_sign;
   logic [7:0]  a_exp, b_exp, p_exp;
   logic [22:0] a_frac, b_frac, p_frac;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   fpm_mul_trunc #(.EXP_W(8), .FRAC_W(23), .STYLE(MULT_SHIFTADD)) dut_i (
      .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac),
      .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac),
      .p_sign(p_sign), .p_exp(p_exp), .p_frac(p_frac)
   );

   // {operand A, operand B, expected product}
   localparam int NV = 12;
   localparam logic [95:0] VEC [NV] = '{
      {32'h3F800000, 32'h3F800000, 32'h3F800000}, // R6 1*1
      {32'h40000000, 32'h40400000, 32'h40C00000}, // R6 2*3
      {32'hBFC00000, 32'h40000000, 32'hC0400000}, // R2 -1.5*2
      {32'h3FC00000, 32'h3FC00000, 32'h40100000}, // R5 1.5*1.5
      {32'hBFC00000, 32'hBFC00000, 32'h40100000}, // R2 neg*neg
      {32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE}, // R7 truncation
      {32'h7F000000, 32'h7F000000, 32'h3E800000}, // R8 high wrap
      {32'h00800000, 32'h00800000, 32'h41800000}, // R8 low wrap
      {32'h00000000, 32'h3F800000, 32'h00000000}, // R1 zero A
      {32'hBF800000, 32'h80000000, 32'h00000000}, // R1 negative zero B
      {32'h007FFFFF, 32'h40000000, 32'h00000000}, // R9 fraction ignored
      {32'hC0000000, 32'h807FFFFF, 32'h00000000}  // R9 fraction ignored
   };

   function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b);
      logic [47:0] pr;
      logic [9:0]  e;
      if (a[30:23] == 8'd0 || b[30:23] == 8'd0) return 32'h0;
      pr = {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
      if (pr[47]) begin
         e = {2'b0, a[30:23]} + {2'b0, b[30:23]} - 10'd126;
         return {a[31] ^ b[31], e[7:0], pr[46:24]};
      end
      e = {2'b0, a[30:23]} + {2'b0, b[30:23]} - 10'd127;
      return {a[31] ^ b[31], e[7:0], pr[45:23]};
   endfunction

   task automatic apply_check(input logic [31:0] a, input logic [31:0] b,
                              input logic [31:0] exp_v, input string req);
      logic [31:0] got;
      @(negedge clk);
      {a_sign, a_exp, a_frac} = a;
      {b_sign, b_exp, b_frac} = b;
      #2;
      got = {p_sign, p_exp, p_frac};
      checks++;
      if (got !== exp_v) begin
         errors++;
         $display("FAIL %s: a=%h b=%h actual=%h expected=%h", req, a, b, got, exp_v);
      end
   endtask

   initial begin
      #1500000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      {a_sign, a_exp, a_frac} = '0;
      {b_sign, b_exp, b_frac} = '0;
      // R1: idle all-zero inputs give positive zero
      apply_check(32'h0, 32'h0, 32'h0, "R1");

      for (int i = 0; i < NV; i++) begin
         apply_check(VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], "R1/R2/R5-R9 table");
      end

      // R5 and R6: branch choice, reference shares only the spec formula
      apply_check(32'h3FFFFFFF, 32'h3F800001, model(32'h3FFFFFFF, 32'h3F800001), "R5");
      apply_check(32'h3F800001, 32'h3F800001, model(32'h3F800001, 32'h3F800001), "R6");
      // R3, R4: powers of two leave the fraction zero
      apply_check(32'h44800000, 32'h3B000000, 32'h40000000, "R3 powers of two");

      for (int i = 0; i < 400; i++) begin
         logic [31:0] a, b;
         a = $urandom;
         b = $urandom;
         a[30:23] = 8'd64 + 8'($urandom_range(0, 126));
         b[30:23] = 8'd64 + 8'($urandom_range(0, 126));
         apply_check(a, b, model(a, b), "R3/R5/R6 random");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule